// File: doc/BRIEF.md
# DMA Channel Status Collector

This block gathers the status bytes of several DMA channels into one read-only global status word. It also merges the channels' interrupt requests into a single line and names the channel that software should handle first. Each channel supplies an 8-bit status field and an interrupt request. The block registers the packed word and the merged interrupt together on every clock edge, so a read always sees one consistent snapshot.

The service pick comes from the registered word itself. The lowest set bit of the whole word selects the channel, so the channel in the least significant byte wins. With channel 0 in the top byte, this gives the highest-numbered channel that has any status bit set. Clearing a status bit is left to each channel's own register file.

Top module: `dstat_agg`

## Requirements
- R1: While reset is asserted and after its release, before the first captured sample, `gstat_word`, `irq_any`, `svc_valid` and `svc_chan` are all zero.
- R2: On input, channel c drives `ch_stat[c*8 +: 8]`. One clock edge later, that byte appears in `gstat_word[31-8c -: 8]`, so channel 0 occupies bits 31:24 and channel 3 occupies bits 7:0.
- R3: A channel's bits are placed without reordering. Within a byte, bit 7 is transfer error, bit 5 is halted, bit 4 is programming error, bit 3 is end of list, bit 2 is busy, bit 1 is end of segment and bit 0 is end of list segment.
- R4: `svc_chan` equals (32 − f) / 8, where f is the 1-based position of the lowest set bit of the current `gstat_word`. It changes in the same cycle as the word.
- R5: When several channels have bits set, the channel whose byte is least significant (the highest channel number) is the one selected.
- R6: When `gstat_word` is zero, `svc_valid` is 0 and `svc_chan` is 0.
- R7: `svc_valid` is 1 exactly when `gstat_word` is nonzero.
- R8: `irq_any` equals the OR of the four `ch_irq` bits sampled at the previous clock edge.
- R9: The interrupt path and the status path are independent. Requests with zero status still raise `irq_any`, and status bits with no request leave it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_stat | input | 32 | Status bytes, channel c at bits c*8+7:c*8 |
| ch_irq | input | 4 | Interrupt request per channel |
| gstat_word | output | 32 | Registered global status word, channel 0 in the top byte |
| irq_any | output | 1 | Registered OR of the channel requests |
| svc_valid | output | 1 | Some status bit is set in the word |
| svc_chan | output | 2 | Channel to service first |

## Verification
The first pattern sweeps a single set bit through all 32 positions. This tells a wrong byte placement or a reversed bit order apart from a correct one, and it covers every value of the lowest-set-bit formula, including both ends of the word. Patterns with several channels active separate lowest-byte priority from highest-byte priority. The all-zero and all-ones words pin down the idle and the saturated pick. Interrupt patterns are crossed against both zero and nonzero status to show that the two paths do not leak into each other.

// File: rtl/dstat_pkg.sv
package dstat_pkg;
   typedef enum logic {PICK_BYTE = 1'b0, PICK_BIT = 1'b1} pick_mode_e;

   localparam int ST_XFER_ERR = 7;
   localparam int ST_HALTED   = 5;
   localparam int ST_PROG_ERR = 4;
   localparam int ST_END_LIST = 3;
   localparam int ST_BUSY     = 2;
   localparam int ST_END_SEG  = 1;
   localparam int ST_END_LSEG = 0;
endpackage

// File: rtl/dstat_pack.sv
module dstat_pack #(
   parameter int NUM_CH  = 4,
   parameter int FIELD_W = 8,
   localparam int W      = NUM_CH * FIELD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [W-1:0]      ch_stat,
   input  logic [NUM_CH-1:0] ch_irq,
   output logic [W-1:0]      word_q,
   output logic              irq_q
);
   logic [W-1:0] word_d;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
      assign word_d[(NUM_CH-1-c)*FIELD_W +: FIELD_W] = ch_stat[c*FIELD_W +: FIELD_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         irq_q  <= 1'b0;
      end else begin
         word_q <= word_d;
         irq_q  <= |ch_irq;
      end
   end
endmodule

// File: rtl/dstat_pick.sv
module dstat_pick
   import dstat_pkg::*;
#(
   parameter int         NUM_CH  = 4,
   parameter int         FIELD_W = 8,
   parameter pick_mode_e MODE    = PICK_BYTE,
   localparam int        W       = NUM_CH * FIELD_W,
   localparam int        IDX_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic [W-1:0]     word,
   output logic             valid,
   output logic [IDX_W-1:0] chan
);
   if (MODE == PICK_BYTE) begin : g_byte
      always_comb begin
         valid = 1'b0;
         chan  = '0;
         for (int c = 0; c < NUM_CH; c++) begin
            if (|word[(NUM_CH-1-c)*FIELD_W +: FIELD_W]) begin
               valid = 1'b1;
               chan  = IDX_W'(c);
            end
         end
      end
   end else begin : g_bit
      always_comb begin
         valid = 1'b0;
         chan  = '0;
         for (int b = W-1; b >= 0; b--) begin
            if (word[b]) begin
               valid = 1'b1;
               chan  = IDX_W'((W - 1 - b) / FIELD_W);
            end
         end
      end
   end
endmodule

// File: rtl/dstat_agg.sv
module dstat_agg
   import dstat_pkg::*;
#(
   parameter int         NUM_CH    = 4,
   parameter int         FIELD_W   = 8,
   parameter pick_mode_e PICK_MODE = PICK_BYTE,
   localparam int        W         = NUM_CH * FIELD_W,
   localparam int        IDX_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [W-1:0]      ch_stat,
   input  logic [NUM_CH-1:0] ch_irq,
   output logic [W-1:0]      gstat_word,
   output logic              irq_any,
   output logic              svc_valid,
   output logic [IDX_W-1:0]  svc_chan
);
   if (NUM_CH < 1) begin : g_bad_ch
      $error("dstat_agg: NUM_CH must be at least 1");
   end
   if (FIELD_W < 1) begin : g_bad_fw
      $error("dstat_agg: FIELD_W must be at least 1");
   end

   dstat_pack #(.NUM_CH(NUM_CH), .FIELD_W(FIELD_W)) u_pack (
      .clk     (clk),
      .rst_n   (rst_n),
      .ch_stat (ch_stat),
      .ch_irq  (ch_irq),
      .word_q  (gstat_word),
      .irq_q   (irq_any)
   );

   dstat_pick #(.NUM_CH(NUM_CH), .FIELD_W(FIELD_W), .MODE(PICK_MODE)) u_pick (
      .word  (gstat_word),
      .valid (svc_valid),
      .chan  (svc_chan)
   );
endmodule

// File: rtl/dstat_agg_chk.sv
module dstat_agg_chk #(
   parameter int  NUM_CH  = 4,
   parameter int  FIELD_W = 8,
   localparam int W       = NUM_CH * FIELD_W,
   localparam int IDX_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [W-1:0]      ch_stat,
   input logic [NUM_CH-1:0] ch_irq,
   input logic [W-1:0]      gstat_word,
   input logic              irq_any,
   input logic              svc_valid,
   input logic [IDX_W-1:0]  svc_chan
);
   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   // winner's byte is nonzero and every byte of a higher channel number is zero
   logic sel_nz, above_zero;
   always_comb begin
      sel_nz     = 1'b0;
      above_zero = 1'b1;
      for (int c = 0; c < NUM_CH; c++) begin
         if (c == int'(svc_chan))
            sel_nz = |gstat_word[(NUM_CH-1-c)*FIELD_W +: FIELD_W];
         else if (c > int'(svc_chan) && (|gstat_word[(NUM_CH-1-c)*FIELD_W +: FIELD_W]))
            above_zero = 1'b0;
      end
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
      a_r2_lane_place: assert property (@(posedge clk) disable iff (!rst_n)
         armed |-> gstat_word[(NUM_CH-1-c)*FIELD_W +: FIELD_W] == $past(ch_stat[c*FIELD_W +: FIELD_W]));
   end

   a_r1_reset_clear: assert property (@(posedge clk) !rst_n |-> gstat_word == '0 && !irq_any);
   a_r5_low_byte_wins: assert property (@(posedge clk) disable iff (!rst_n)
      svc_valid |-> sel_nz && above_zero);
   a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      gstat_word == '0 |-> !svc_valid && svc_chan == '0);
   a_r7_valid_set: assert property (@(posedge clk) disable iff (!rst_n)
      gstat_word != '0 |-> svc_valid);
   a_r8_irq_merge: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> irq_any == $past(|ch_irq));
endmodule

bind dstat_agg dstat_agg_chk #(.NUM_CH(NUM_CH), .FIELD_W(FIELD_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ch_stat    (ch_stat),
   .ch_irq     (ch_irq),
   .gstat_word (gstat_word),
   .irq_any    (irq_any),
   .svc_valid  (svc_valid),
   .svc_chan   (svc_chan)
);

// File: tb/tb_dstat_agg.sv
module tb_dstat_agg;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] ch_stat = '0;
   logic [3:0]  ch_irq = '0;
   logic [31:0] gstat_word;
   logic        irq_any;
   logic        svc_valid;
   logic [1:0]  svc_chan;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic [31:0] word;
      logic        irq;
      logic        valid;
      logic [1:0]  chan;
      string       tag;
   } exp_t;
   exp_t sb[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   dstat_agg dut (
      .clk(clk), .rst_n(rst_n), .ch_stat(ch_stat), .ch_irq(ch_irq),
      .gstat_word(gstat_word), .irq_any(irq_any),
      .svc_valid(svc_valid), .svc_chan(svc_chan)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
      end
   endtask

   task automatic drive(input logic [7:0] s0, s1, s2, s3,
                        input logic [3:0] irq, input string tag);
      exp_t e;
      int f;
      @(negedge clk);
      ch_stat = {s3, s2, s1, s0};
      ch_irq  = irq;
      e.word  = {s0, s1, s2, s3};
      f = 0;
      for (int b = 31; b >= 0; b--) if (e.word[b]) f = b + 1;
      e.chan  = (f != 0) ? 2'((32 - f) / 8) : 2'd0;
      e.valid = (e.word != 0);
      e.irq   = |irq;
      e.tag   = tag;
      sb.push_back(e);
   endtask

   // monitor: compares one cycle after each drive
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(gstat_word === e.word, {e.tag, " R2"}, "word", gstat_word, e.word);
            check(irq_any === e.irq, {e.tag, " R8"}, "irq", 32'(irq_any), 32'(e.irq));
            check(svc_valid === e.valid, {e.tag, " R7"}, "valid", 32'(svc_valid), 32'(e.valid));
            check(svc_chan === e.chan, {e.tag, " R4"}, "chan", 32'(svc_chan), 32'(e.chan));
         end
      end
   end

   initial begin
      repeat (1000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      ch_stat = 32'hFFFF_FFFF;
      ch_irq  = 4'hF;
      repeat (3) @(negedge clk);
      // R1: reset holds everything at zero despite active inputs
      check(gstat_word === '0, "R1", "word", gstat_word, 0);
      check(irq_any === 1'b0, "R1", "irq", 32'(irq_any), 0);
      check(svc_valid === 1'b0, "R1", "valid", 32'(svc_valid), 0);
      check(svc_chan === 2'd0, "R1", "chan", 32'(svc_chan), 0);
      ch_stat = '0;
      ch_irq  = '0;
      @(negedge clk);
      rst_n = 1'b1;

      // R2 R3 R4: single bit walks all 32 positions
      for (int b = 0; b < 32; b++) begin
         logic [31:0] w;
         w = 32'h1 << b;
         drive(w[31:24], w[23:16], w[15:8], w[7:0], 4'h0, "R3 walk");
      end
      // R3: named fields of channel 1 (error, halted, busy, end of segment)
      drive(8'h00, 8'hA6, 8'h00, 8'h00, 4'h0, "R3 fields");
      // R5: several channels active, least significant byte wins
      drive(8'h01, 8'h80, 8'h00, 8'h00, 4'h0, "R5 ch0+ch1");
      drive(8'hFF, 8'h00, 8'h04, 8'h00, 4'h0, "R5 ch0+ch2");
      drive(8'h10, 8'h20, 8'h08, 8'h80, 4'h0, "R5 all");
      drive(8'hFF, 8'hFF, 8'hFF, 8'hFF, 4'h0, "R5 ones");
      // R6: zero word
      drive(8'h00, 8'h00, 8'h00, 8'h00, 4'h0, "R6 zero");
      // R9 R8: interrupt path independent of status
      drive(8'h00, 8'h00, 8'h00, 8'h00, 4'h4, "R9 irq only");
      drive(8'h00, 8'h00, 8'h00, 8'h00, 4'h1, "R8 irq ch0");
      drive(8'h00, 8'h00, 8'h00, 8'h00, 4'h8, "R8 irq ch3");
      drive(8'h80, 8'h00, 8'h00, 8'h01, 4'h0, "R9 stat only");
      drive(8'h00, 8'h02, 8'h00, 8'h00, 4'hF, "R8 both");
      drive(8'h00, 8'h00, 8'h00, 8'h00, 4'h0, "R6 idle");

      @(posedge clk);
      #2;
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule